// File: doc/BRIEF.md
# Power Domain Gating Sequencer

This block switches one logic domain off and back on in hardware. It keeps a single 32-bit control/status image. That image drives eight staged power-switch segments, the isolation clamp, the domain reset release and three retention enables. It also shows the two switch status flags that come back from the analog power switch. A power-down request or a power-up request starts a fixed ordering of single-bit changes. After each control change the block waits a settling time counted in ticks of a 4 MHz timebase. At the points in the ordering where the switch must report its state, the block stops until the status flag reaches the expected level.

The status flags pass through a two-flop synchronizer before they are used. Between sequences, the control image can be written directly. Such a write only takes effect if its top byte carries the write key. The current step index is visible on the ports, so the ordering can be checked against a reference.

Top module: `pd_gate_seq`

## Requirements
- R1: After reset the control bits of `ctrl_o` are 0x0001_70FF: all switch segments on, all three retention enables on, isolation off and reset released. `busy_o`=0, `done_o`=0, `dom_on_o`=1 and `step_o`=0.
- R2: Image layout:
  - bits [7:0] are the switch segment enables;
  - bit 12 is SRAM retention, bit 13 is SRAM retention pre-enable and bit 14 is DDR retention;
  - bit 15 is isolation and bit 16 is reset release (1 = released);
  - bit 8 mirrors the switch-A status input and bit 9 mirrors the switch-D status input, each two clocks after the input changes;
  - bits [11:10] and [31:17] read as zero.
- R3: A direct write (`wr_en_i`) changes the image only if `wr_data_i[31:24]` equals 0x27 and no sequence is running. A rejected write leaves the image unchanged.
- R4: Power-down changes the image in this order:
  - clear reset, then set isolation;
  - clear DDR retention, then the SRAM retention pre-enable, then SRAM retention;
  - clear switch bits 7, 6, …, 0.
- R5: Power-up changes the image in this order:
  - set switch bits 0, 1, …, 7;
  - set SRAM retention, then the pre-enable, then DDR retention;
  - clear isolation, then set reset.
- R6: Each control change alters exactly one bit. Consecutive changes within a sequence are at least `SETTLE_TICKS` ticks apart (800 by default, 200 us at 4 MHz).
- R7: Status polls have no timeout.
  - Power-down blocks after the retention steps until switch D reads low, and only then until switch A reads low.
  - Power-up blocks after the last switch bit until switch A reads high, and only then until switch D reads high.
- R8: A power-up request while the domain is on, or a power-down request while it is off, raises `done_o` one clock later. The image does not change.
- R9: At the end of a sequence `done_o` pulses for one clock with `busy_o` low. `dom_on_o` then shows the new domain state. Requests arriving during a sequence are ignored.
- R10: `step_o` gives the index of the step in progress.
  - Power-down: the D poll is step 5 and the first switch release is step 7.
  - Power-up: the A poll is step 8.
- R11: When both requests arrive in the same cycle, the power-down request wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-clock pulse per 4 MHz timebase tick |
| pd_req_i | input | 1 | Power-down request |
| pu_req_i | input | 1 | Power-up request |
| sw_a_ok_i | input | 1 | Switch A status (asynchronous) |
| sw_d_ok_i | input | 1 | Switch D status (asynchronous) |
| wr_en_i | input | 1 | Direct image write strobe |
| wr_data_i | input | 32 | Direct write data, key in [31:24] |
| ctrl_o | output | 32 | Control/status image |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-clock completion pulse |
| step_o | output | 4 | Current step index |
| dom_on_o | output | 1 | Domain is powered |

## Verification
The assertions assume three things about the inputs:
- `tick_i` is a single-clock pulse that never stays high two clocks in a row;
- requests are short pulses;
- direct writes are issued only while the block is idle if they are meant to take effect.

The settle-gap property allows a slack of a few ticks, to cover the register stages between a write and its appearance on `ctrl_o`. The stimulus follows these rules:
- it drives `tick_i` every second clock and pulses each request for one clock;
- it changes the status flags only on clock edges opposite to the active edge;
- it holds each flag at the wrong level for thousands of clocks to show the blocking poll, including the case where only the flag polled second has moved.

// File: rtl/pdg_pkg.sv
package pdg_pkg;
  localparam int unsigned IMG_W = 32;
  localparam logic [7:0] WR_KEY = 8'h27;
  localparam int SW_SEGS  = 8;
  localparam int B_STAT_A = 8;
  localparam int B_STAT_D = 9;
  localparam int B_RET_SRAM = 12;
  localparam int B_RET_PRE  = 13;
  localparam int B_RET_DDR  = 14;
  localparam int B_ISO      = 15;
  localparam int B_RST      = 16;
  localparam logic [IMG_W-1:0] CTL_MASK  = 32'h0001_F0FF;
  localparam logic [IMG_W-1:0] CTL_RESET = 32'h0001_70FF;
  localparam int STEP_W = 4;
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(2 * SW_SEGS - 2);

  typedef enum logic [1:0] {ACT_SET, ACT_CLR, ACT_POLL_A, ACT_POLL_D} act_e;
  typedef enum logic {DIR_DOWN, DIR_UP} dir_e;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_WAIT, ST_DONE} st_e;

  typedef struct packed {
    act_e       act;
    logic [4:0] pos;
    logic       lvl;
  } step_t;

  // Step table for both orderings, indexed 0..LAST_STEP.
  function automatic step_t step_of(dir_e d, logic [STEP_W-1:0] i);
    step_t s;
    s.act = ACT_SET;
    s.pos = 5'd0;
    s.lvl = 1'b0;
    if (d == DIR_DOWN) begin
      case (i)
        4'd0: begin s.act = ACT_CLR; s.pos = 5'(B_RST); end
        4'd1: begin s.act = ACT_SET; s.pos = 5'(B_ISO); end
        4'd2: begin s.act = ACT_CLR; s.pos = 5'(B_RET_DDR); end
        4'd3: begin s.act = ACT_CLR; s.pos = 5'(B_RET_PRE); end
        4'd4: begin s.act = ACT_CLR; s.pos = 5'(B_RET_SRAM); end
        4'd5: begin s.act = ACT_POLL_D; s.lvl = 1'b0; end
        4'd6: begin s.act = ACT_POLL_A; s.lvl = 1'b0; end
        default: begin s.act = ACT_CLR; s.pos = 5'd14 - {1'b0, i}; end
      endcase
    end else begin
      case (i)
        4'd8:  begin s.act = ACT_POLL_A; s.lvl = 1'b1; end
        4'd9:  begin s.act = ACT_POLL_D; s.lvl = 1'b1; end
        4'd10: begin s.act = ACT_SET; s.pos = 5'(B_RET_SRAM); end
        4'd11: begin s.act = ACT_SET; s.pos = 5'(B_RET_PRE); end
        4'd12: begin s.act = ACT_SET; s.pos = 5'(B_RET_DDR); end
        4'd13: begin s.act = ACT_CLR; s.pos = 5'(B_ISO); end
        4'd14: begin s.act = ACT_SET; s.pos = 5'(B_RST); end
        default: begin s.act = ACT_SET; s.pos = {1'b0, i}; end
      endcase
    end
    return s;
  endfunction
endpackage

// File: rtl/pdg_sync.sv
module pdg_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      logic [W-1:0] src;
      if (k == 0) begin : g_first
        assign src = d_i;
      end else begin : g_chain
        assign src = stg[k-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[k] <= '0;
        else        stg[k] <= src;
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pdg_timer.sv
module pdg_timer #(
  parameter int TICKS = 800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic tick_i,
  output logic expired_o
);
  localparam int CW = (TICKS < 2) ? 1 : $clog2(TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TICKS);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          act_q, act_n;
  logic          at_limit;

  assign at_limit  = (cnt_q == LIMIT);
  assign expired_o = act_q && at_limit;

  always_comb begin
    cnt_n = cnt_q;
    act_n = act_q;
    if (start_i) begin
      cnt_n = '0;
      act_n = 1'b1;
    end else if (act_q) begin
      if (at_limit)    act_n = 1'b0;
      else if (tick_i) cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      act_q <= act_n;
    end
  end
endmodule

// File: rtl/pdg_regimg.sv
module pdg_regimg
  import pdg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [IMG_W-1:0] wr_data_i,
  input  logic [1:0]       stat_i,
  output logic [IMG_W-1:0] ctl_o,
  output logic [IMG_W-1:0] img_o
);
  logic [IMG_W-1:0] ctl_q, ctl_n;
  logic             key_ok, ld_en;

  assign key_ok = (wr_data_i[31:24] == WR_KEY);
  assign ld_en  = wr_en_i && key_ok;

  always_comb begin
    ctl_n = ctl_q;
    if (ld_en) ctl_n = wr_data_i & CTL_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= CTL_RESET;
    else        ctl_q <= ctl_n;
  end

  assign ctl_o = ctl_q;
  assign img_o = ctl_q | {22'b0, stat_i[1], stat_i[0], 8'b0};
endmodule

// File: rtl/pdg_fsm.sv
module pdg_fsm
  import pdg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pd_req_i,
  input  logic              pu_req_i,
  input  logic [1:0]        stat_i,
  input  logic [IMG_W-1:0]  ctl_i,
  input  logic              tmr_exp_i,
  output logic              seq_wr_o,
  output logic [IMG_W-1:0]  seq_data_o,
  output logic              tmr_start_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              idle_o,
  output logic [STEP_W-1:0] step_o,
  output logic              on_o
);
  st_e               st_q, st_n;
  dir_e              dir_q, dir_n;
  logic [STEP_W-1:0] idx_q, idx_n;
  logic              on_q, on_n;
  step_t             cur;
  logic              is_poll, poll_hit, is_last;
  logic [IMG_W-1:0]  nxt_ctl;

  always_comb cur = step_of(dir_q, idx_q);

  assign is_poll = (cur.act == ACT_POLL_A) || (cur.act == ACT_POLL_D);
  assign is_last = (idx_q == LAST_STEP);

  always_comb begin
    case (cur.act)
      ACT_POLL_A: poll_hit = (stat_i[0] == cur.lvl);
      ACT_POLL_D: poll_hit = (stat_i[1] == cur.lvl);
      default:    poll_hit = 1'b0;
    endcase
  end

  always_comb begin
    nxt_ctl = ctl_i;
    if (cur.act == ACT_SET)      nxt_ctl[cur.pos] = 1'b1;
    else if (cur.act == ACT_CLR) nxt_ctl[cur.pos] = 1'b0;
  end

  always_comb begin
    st_n        = st_q;
    dir_n       = dir_q;
    idx_n       = idx_q;
    on_n        = on_q;
    seq_wr_o    = 1'b0;
    tmr_start_o = 1'b0;
    case (st_q)
      ST_IDLE: begin
        idx_n = '0;
        if (pd_req_i) begin
          dir_n = DIR_DOWN;
          st_n  = on_q ? ST_RUN : ST_DONE;
        end else if (pu_req_i) begin
          dir_n = DIR_UP;
          st_n  = on_q ? ST_DONE : ST_RUN;
        end
      end
      ST_RUN: begin
        if (is_poll) begin
          if (poll_hit) begin
            if (is_last) st_n = ST_DONE;
            else         idx_n = idx_q + 1'b1;
          end
        end else begin
          seq_wr_o    = 1'b1;
          tmr_start_o = 1'b1;
          st_n        = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (tmr_exp_i) begin
          if (is_last) st_n = ST_DONE;
          else begin
            idx_n = idx_q + 1'b1;
            st_n  = ST_RUN;
          end
        end
      end
      default: begin
        on_n  = (dir_q == DIR_UP);
        idx_n = '0;
        st_n  = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      dir_q <= DIR_UP;
      idx_q <= '0;
      on_q  <= 1'b1;
    end else begin
      st_q  <= st_n;
      dir_q <= dir_n;
      idx_q <= idx_n;
      on_q  <= on_n;
    end
  end

  assign seq_data_o = {WR_KEY, nxt_ctl[23:0]};
  assign busy_o     = (st_q == ST_RUN) || (st_q == ST_WAIT);
  assign done_o     = (st_q == ST_DONE);
  assign idle_o     = (st_q == ST_IDLE);
  assign step_o     = idx_q;
  assign on_o       = on_q;
endmodule

// File: rtl/pd_gate_seq.sv
module pd_gate_seq
  import pdg_pkg::*;
#(
  parameter int SETTLE_TICKS = 800,
  parameter int SYNC_STAGES  = 2,
  parameter int RST_STAGES   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        pd_req_i,
  input  logic        pu_req_i,
  input  logic        sw_a_ok_i,
  input  logic        sw_d_ok_i,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] ctrl_o,
  output logic        busy_o,
  output logic        done_o,
  output logic [3:0]  step_o,
  output logic        dom_on_o
);
  logic             rst_ns;
  logic [1:0]       stat_s;
  logic             seq_wr, tmr_start, tmr_exp, idle;
  logic [IMG_W-1:0] seq_data, ctl;
  logic             img_wr, ext_ok;
  logic [IMG_W-1:0] img_data;

  pdg_sync #(.W(1), .STAGES(RST_STAGES)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d_i(1'b1), .q_o(rst_ns)
  );

  pdg_sync #(.W(2), .STAGES(SYNC_STAGES)) u_stat_sync (
    .clk(clk), .rst_n(rst_ns), .d_i({sw_d_ok_i, sw_a_ok_i}), .q_o(stat_s)
  );

  pdg_timer #(.TICKS(SETTLE_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_ns), .start_i(tmr_start), .tick_i(tick_i),
    .expired_o(tmr_exp)
  );

  pdg_fsm u_fsm (
    .clk(clk), .rst_n(rst_ns), .pd_req_i(pd_req_i), .pu_req_i(pu_req_i),
    .stat_i(stat_s), .ctl_i(ctl), .tmr_exp_i(tmr_exp),
    .seq_wr_o(seq_wr), .seq_data_o(seq_data), .tmr_start_o(tmr_start),
    .busy_o(busy_o), .done_o(done_o), .idle_o(idle), .step_o(step_o),
    .on_o(dom_on_o)
  );

  assign ext_ok   = wr_en_i && idle;
  assign img_wr   = seq_wr || ext_ok;
  assign img_data = seq_wr ? seq_data : wr_data_i;

  pdg_regimg u_img (
    .clk(clk), .rst_n(rst_ns), .wr_en_i(img_wr), .wr_data_i(img_data),
    .stat_i(stat_s), .ctl_o(ctl), .img_o(ctrl_o)
  );
endmodule

// File: rtl/pdg_chk.sv
module pdg_chk
  import pdg_pkg::*;
#(
  parameter int SETTLE_TICKS = 800
) (
  input logic        clk,
  input logic        rst_n,
  input logic        tick_i,
  input logic        pd_req_i,
  input logic        pu_req_i,
  input logic        wr_en_i,
  input logic [31:0] wr_data_i,
  input logic [31:0] ctrl_o,
  input logic        busy_o,
  input logic        done_o,
  input logic        dom_on_o
);
  logic [31:0] ctl, prev_ctl;
  logic        chg, armed;
  int unsigned gap;

  assign ctl = ctrl_o & CTL_MASK;
  assign chg = (ctl != prev_ctl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_ctl <= CTL_RESET;
      gap      <= 0;
      armed    <= 1'b0;
    end else begin
      prev_ctl <= ctl;
      if (chg)                         gap <= 0;
      else if (tick_i && gap < 32'hFFFF_FFF0) gap <= gap + 1;
      armed <= busy_o ? (armed || chg) : 1'b0;
    end
  end

  AST_KEY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !done_o && wr_en_i && wr_data_i[31:24] != WR_KEY)
      |=> $stable(ctrl_o & CTL_MASK)); // R3

  AST_ONE_BIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> ($countones(ctl ^ prev_ctl) <= 1)); // R6

  AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && armed && chg) |-> (gap + 3 >= SETTLE_TICKS)); // R6

  AST_ISO_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && ctl[7:0] != 8'hFF) |-> ctl[B_ISO]); // R4

  AST_REDUNDANT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !done_o && pu_req_i && !pd_req_i && dom_on_o)
      |=> (done_o && $stable(ctrl_o & CTL_MASK))); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o)); // R9
endmodule

bind pd_gate_seq pdg_chk #(.SETTLE_TICKS(SETTLE_TICKS)) u_chk (
  .clk(clk), .rst_n(rst_ns), .tick_i(tick_i), .pd_req_i(pd_req_i),
  .pu_req_i(pu_req_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
  .ctrl_o(ctrl_o), .busy_o(busy_o), .done_o(done_o), .dom_on_o(dom_on_o)
);

// File: tb/tb_pd_gate_seq.sv
module tb_pd_gate_seq;
  import pdg_pkg::*;
  localparam int TICKS = 800;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic pd_req = 1'b0, pu_req = 1'b0, sa = 1'b1, sd = 1'b1, wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] ctrl;
  logic busy, done, dom_on;
  logic [3:0] step;

  always #2 clk = ~clk;

  pd_gate_seq #(.SETTLE_TICKS(TICKS)) dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .pd_req_i(pd_req),
    .pu_req_i(pu_req), .sw_a_ok_i(sa), .sw_d_ok_i(sd), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .ctrl_o(ctrl), .busy_o(busy), .done_o(done),
    .step_o(step), .dom_on_o(dom_on)
  );

  typedef struct {
    logic [31:0] img;
    string       tag;
  } exp_t;

  exp_t        exp_q[$];
  int          n_chk = 0, n_err = 0;
  logic [31:0] ref_img = CTL_RESET;
  logic [31:0] last_ctl = CTL_RESET;
  logic [31:0] snap;
  bit          mon_on = 1'b0, gap_armed = 1'b0;
  int          gap = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic expect_bit(input int pos, input bit val, input string tag);
    exp_t e;
    ref_img[pos] = val;
    e.img = ref_img;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: pops the scoreboard on every control-image change, drives tick.
  always @(negedge clk) begin
    logic [31:0] cur;
    cur = ctrl & CTL_MASK;
    if (mon_on) begin
      if (cur != last_ctl) begin
        if (exp_q.size() == 0) check(1'b0, "R3", "unrequested change", cur, last_ctl);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          check(cur == e.img, e.tag, "image order", cur, e.img);
        end
        if (gap_armed && busy) check(gap >= TICKS - 2, "R6", "settle gap", gap, TICKS);
        gap = 0;
        gap_armed = busy;
      end else if (tick) gap++;
      if (!busy) gap_armed = 1'b0;
    end
    last_ctl = cur;
    tick = ~tick;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ext_write(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse(input bit pd, input bit pu);
    @(negedge clk); pd_req = pd; pu_req = pu;
    @(negedge clk); pd_req = 1'b0; pu_req = 1'b0;
  endtask

  task automatic wait_step(input logic [3:0] s);
    while (step != s) @(negedge clk);
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    cyc(5);
    rst_n = 1'b1;
    cyc(4);
    mon_on = 1'b1;
    // R1 reset state
    check((ctrl & CTL_MASK) == CTL_RESET, "R1", "reset image", ctrl & CTL_MASK, CTL_RESET);
    check({busy, done, dom_on} == 3'b001, "R1", "busy/done/on", {busy, done, dom_on}, 3'b001);
    check(step == 4'd0, "R1", "step", step, 0);

    // R2 status mirror and reserved bits
    cyc(3);
    check(ctrl[9:8] == 2'b11, "R2", "status bits", ctrl[9:8], 2'b11);
    check(ctrl[31:17] == 0 && ctrl[11:10] == 0, "R2", "reserved zero", ctrl, CTL_RESET | 32'h300);
    sa = 1'b0;
    cyc(1);
    check(ctrl[8] == 1'b1, "R2", "sync stage 1", ctrl[8], 1);
    cyc(1);
    check(ctrl[8] == 1'b0, "R2", "sync stage 2", ctrl[8], 0);
    sa = 1'b1;
    cyc(3);

    // R3 key check
    ext_write({8'h26, 24'h0} | (ref_img & ~32'h1));
    cyc(1);
    check((ctrl & CTL_MASK) == ref_img, "R3", "bad key", ctrl & CTL_MASK, ref_img);
    expect_bit(0, 1'b0, "R3");
    ext_write({WR_KEY, 24'h0} | ref_img);
    cyc(1);
    check((ctrl & CTL_MASK) == ref_img, "R3", "good key", ctrl & CTL_MASK, ref_img);
    expect_bit(0, 1'b1, "R3");
    ext_write({WR_KEY, 24'h0} | ref_img | 32'h0000_0C00);
    cyc(1);
    check(ctrl[11:10] == 2'b00, "R2", "reserved ignored", ctrl[11:10], 0);

    // R8 redundant power-up
    @(negedge clk); pu_req = 1'b1;
    @(negedge clk); pu_req = 1'b0;
    check(done && !busy, "R8", "redundant up done", {busy, done}, 2'b01);
    cyc(1);
    check((ctrl & CTL_MASK) == ref_img && dom_on, "R8", "no change", ctrl & CTL_MASK, ref_img);

    // R4 power-down
    expect_bit(B_RST, 1'b0, "R4");
    expect_bit(B_ISO, 1'b1, "R4");
    expect_bit(B_RET_DDR, 1'b0, "R4");
    expect_bit(B_RET_PRE, 1'b0, "R4");
    expect_bit(B_RET_SRAM, 1'b0, "R4");
    for (int k = SW_SEGS - 1; k >= 0; k--) expect_bit(k, 1'b0, "R4");
    pulse(1'b1, 1'b0);
    check(busy, "R9", "busy after start", busy, 1);
    wait_step(4'd5);
    check(step == 4'd5, "R10", "D poll index", step, 5);
    cyc(3000);
    check(step == 4'd5 && busy, "R7", "blocked on D", step, 5);
    snap = ctrl & CTL_MASK;
    ext_write({WR_KEY, 24'h0});
    pulse(1'b0, 1'b1);
    cyc(2);
    check((ctrl & CTL_MASK) == snap, "R3", "write while busy", ctrl & CTL_MASK, snap);
    sa = 1'b0;
    cyc(2000);
    check(step == 4'd5, "R7", "A low alone", step, 5);
    sd = 1'b0;
    cyc(20);
    check(step == 4'd7, "R10", "first release index", step, 7);
    wait_done();
    check(!busy, "R9", "done not busy", busy, 0);
    cyc(1);
    check(!dom_on && !done, "R9", "domain off", {dom_on, done}, 0);
    check(exp_q.size() == 0, "R4", "all steps seen", exp_q.size(), 0);

    // R11 both requests while off: power-down wins (redundant)
    @(negedge clk); pd_req = 1'b1; pu_req = 1'b1;
    @(negedge clk); pd_req = 1'b0; pu_req = 1'b0;
    check(done && !busy, "R11", "pd priority", {busy, done}, 2'b01);
    cyc(2);
    check(!dom_on && (ctrl & CTL_MASK) == ref_img, "R11", "stays off", ctrl & CTL_MASK, ref_img);
    // R8 redundant power-down
    @(negedge clk); pd_req = 1'b1;
    @(negedge clk); pd_req = 1'b0;
    check(done, "R8", "redundant down done", done, 1);
    cyc(2);

    // R5 power-up
    for (int k = 0; k < SW_SEGS; k++) expect_bit(k, 1'b1, "R5");
    expect_bit(B_RET_SRAM, 1'b1, "R5");
    expect_bit(B_RET_PRE, 1'b1, "R5");
    expect_bit(B_RET_DDR, 1'b1, "R5");
    expect_bit(B_ISO, 1'b0, "R5");
    expect_bit(B_RST, 1'b1, "R5");
    pulse(1'b0, 1'b1);
    wait_step(4'd8);
    check(step == 4'd8, "R10", "A poll index", step, 8);
    cyc(3000);
    check(step == 4'd8 && busy, "R7", "blocked on A", step, 8);
    sd = 1'b1;
    cyc(2000);
    check(step == 4'd8, "R7", "D high alone", step, 8);
    sa = 1'b1;
    wait_done();
    cyc(1);
    check(dom_on, "R9", "domain on", dom_on, 1);
    check((ctrl & CTL_MASK) == CTL_RESET, "R5", "final image", ctrl & CTL_MASK, CTL_RESET);
    check(exp_q.size() == 0, "R5", "all steps seen", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule